// File: doc/BRIEF.md
# Attribute-Cell Display Fetch Engine

This block produces a 256 by 192 pixel bitmap picture. The picture is split into 8 by 8 pixel cells, and every pixel in a cell takes its colours from one attribute byte shared by the cell. The engine runs a raster counter and reads bitmap and attribute bytes from a shared video memory through a synchronous read port. It turns each bitmap byte into eight pixels and gives out one 4-bit colour index on every pixel clock.

The video memory holds 6912 bytes. The 6144 bitmap bytes come first, and their scanlines are interleaved rather than stored in order. The 768 attribute bytes follow them. The engine and the processor share that memory, and the engine always has priority. In every clock that carries an engine read, the engine pulls down the processor's clock enable, so the processor stalls and never sees the access. Border colour, sync shaping and analog output are handled elsewhere.

Top module: `attr_cell_fetch`

## Requirements
- R1: While `rst` is high (synchronous, active high), `de` is 0, `pix` is 0, `rd_en` is 0 and `cpu_ce` is 1.
- R2: A line lasts `H_TOTAL` clocks and a frame lasts `V_TOTAL` lines. After reset is released, `de` first reads 1 after the (`H_TOTAL`+1)th rising edge. Each frame then shows 192 runs of exactly 256 consecutive `de`-high clocks.
- R3: The bitmap byte for line y (0..191) and byte column x (0..31) is read from address {y[7:6], y[2:0], y[5:3], x[4:0]}.
- R4: The attribute byte for that cell is read from 6144 + (y/8)*32 + x, in the clock right after the cell's bitmap read.
- R5: `rd_data` is taken one clock after the clock in which `rd_en` was high with the matching `rd_addr`.
- R6: Pixels leave each bitmap byte most significant bit first. A set bit gives `pix` = {attr[6], attr[2:0]} (bright, ink). A clear bit gives {attr[6], attr[5:3]} (bright, paper).
- R7: Attribute bit 7 has no effect on `pix`.
- R8: `cpu_ce` is 0 in exactly those clocks in which `rd_en` is 1, and 1 in all other clocks. A frame has 2*32*192 such clocks.
- R9: `pix` is 0 in every clock in which `de` is 0.
- R10: A cell's two reads take place within the 8 clocks before the cell is shown, in raster order. No read is made for a cell outside the active area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_data | input | 8 | Video memory read data, valid one clock after the request |
| rd_en | output | 1 | Video memory read request |
| rd_addr | output | 13 | Video memory byte address |
| cpu_ce | output | 1 | Processor clock enable, low while the engine holds the bus |
| de | output | 1 | Active-area flag for `pix` |
| pix | output | 4 | Colour index {bright, 3-bit colour} |

## Verification
The bench builds the engine with `H_TOTAL`=272 and `V_TOTAL`=196. These are the smallest convenient totals that still leave room for the 8-clock fetch ahead of column 0. With them, two full frames, the wrap from the last blank line into line 0, and a second reset all fit in a short run. The first frame uses a hashed memory image, so every address bit and ink/paper choice is exercised. The second frame sets attribute bit 7 on every cell, which tests that this bit has no effect.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int ACT_W     = 256;
  localparam int ACT_H     = 192;
  localparam int CELL      = 8;
  localparam int COLS      = ACT_W / CELL;
  localparam int ADDR_W    = 13;
  localparam int ATTR_BASE = ACT_W * ACT_H / CELL;
  localparam int MAP_BYTES = ATTR_BASE + COLS * (ACT_H / CELL);
  localparam int CIDX_W    = 4;

  typedef struct packed {
    logic       ok;
    logic [4:0] fx;
    logic [7:0] fy;
  } tgt_t;

  typedef struct packed {
    logic valid;
    logic is_attr;
  } rd_tag_t;

  function automatic logic [ADDR_W-1:0] bitmap_addr(input logic [7:0] y, input logic [4:0] x);
    return {y[7:6], y[2:0], y[5:3], x};
  endfunction

  function automatic logic [ADDR_W-1:0] attr_addr(input logic [7:0] y, input logic [4:0] x);
    return ADDR_W'(ATTR_BASE) + {3'b000, y[7:3], x};
  endfunction

  function automatic logic [CIDX_W-1:0] cell_colour(input logic b, input logic [7:0] at);
    return {at[6], (b ? at[2:0] : at[5:3])};
  endfunction
endpackage

// File: rtl/acf_raster.sv
module acf_raster #(
  parameter int H_TOTAL = 448,
  parameter int V_TOTAL = 312,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc,
  output logic [HW-1:0] hc_nxt,
  output logic [VW-1:0] vc_nxt,
  output logic          line_wrap
);
  assign line_wrap = (hc == HW'(H_TOTAL - 1));

  always_comb begin
    hc_nxt = line_wrap ? '0 : hc + 1'b1;
    vc_nxt = vc;
    if (line_wrap) vc_nxt = (vc == VW'(V_TOTAL - 1)) ? '0 : vc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= VW'(V_TOTAL - 1);
    end else begin
      hc <= hc_nxt;
      vc <= vc_nxt;
    end
  end

  assert_line_length_R2: assert property (@(posedge clk) disable iff (rst)
    line_wrap |=> (hc == '0));
  assert_line_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (line_wrap && vc != VW'(V_TOTAL - 1)) |=> (vc == $past(vc) + 1'b1));
  assert_counter_range_R2: assert property (@(posedge clk) disable iff (rst)
    (hc < HW'(H_TOTAL)) && (vc < VW'(V_TOTAL)));
endmodule

// File: rtl/acf_fetch_seq.sv
module acf_fetch_seq
  import acf_pkg::*;
#(
  parameter int H_TOTAL = 448,
  parameter int V_TOTAL = 312,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int SW = HW - 3,
  localparam int SLOTS = H_TOTAL / CELL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     hc,
  input  logic [VW-1:0]     vc,
  input  logic [HW-1:0]     hc_nxt,
  input  logic [VW-1:0]     vc_nxt,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cpu_ce,
  output logic              cap_bm,
  output logic              cap_at,
  output logic              load_cell
);
  // Cell targeted by the 8-clock slot holding position (h, v): the next cell in raster order.
  function automatic tgt_t aim(input logic [HW-1:0] h, input logic [VW-1:0] v);
    logic [SW-1:0] s;
    logic [SW-1:0] nx;
    logic [VW-1:0] ny;
    tgt_t t;
    s = h[HW-1:3];
    if (s == SW'(SLOTS - 1)) begin
      nx = '0;
      ny = (v == VW'(V_TOTAL - 1)) ? '0 : v + 1'b1;
    end else begin
      nx = s + 1'b1;
      ny = v;
    end
    t.ok = (nx < SW'(COLS)) && (ny < VW'(ACT_H));
    t.fx = nx[4:0];
    t.fy = ny[7:0];
    return t;
  endfunction

  tgt_t    cur_t, nxt_t;
  rd_tag_t tag_q;
  logic    slot_busy_nxt;

  assign cur_t   = aim(hc, vc);
  assign nxt_t   = aim(hc_nxt, vc_nxt);
  assign rd_en   = cur_t.ok && (hc[2:1] == 2'b00);
  assign rd_addr = hc[0] ? attr_addr(cur_t.fy, cur_t.fx) : bitmap_addr(cur_t.fy, cur_t.fx);

  assign slot_busy_nxt = nxt_t.ok && (hc_nxt[2:1] == 2'b00);
  assign cap_bm    = tag_q.valid && !tag_q.is_attr;
  assign cap_at    = tag_q.valid && tag_q.is_attr;
  assign load_cell = (hc[2:0] == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce <= 1'b1;
      tag_q  <= '0;
    end else begin
      cpu_ce        <= !slot_busy_nxt;
      tag_q.valid   <= rd_en;
      tag_q.is_attr <= hc[0];
    end
  end

  assert_ce_withheld_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !cpu_ce);
  assert_ce_released_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> cpu_ce);
  assert_attr_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hc[0]) |=> (rd_en && rd_addr >= ADDR_W'(ATTR_BASE)));
  assert_addr_in_map_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr < ADDR_W'(MAP_BYTES)));
endmodule

// File: rtl/acf_serializer.sv
module acf_serializer
  import acf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rd_data,
  input  logic              cap_bm,
  input  logic              cap_at,
  input  logic              load_cell,
  input  logic              disp_on,
  output logic              de,
  output logic [CIDX_W-1:0] pix
);
  logic [7:0] bm_buf, at_buf, shreg, at_cur;
  logic       px_bit;

  assign px_bit = shreg[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      bm_buf <= '0;
      at_buf <= '0;
      shreg  <= '0;
      at_cur <= '0;
      de     <= 1'b0;
      pix    <= '0;
    end else begin
      if (cap_bm) bm_buf <= rd_data;
      if (cap_at) at_buf <= rd_data;
      if (load_cell) begin
        shreg  <= bm_buf;
        at_cur <= at_buf;
      end else begin
        shreg <= {shreg[6:0], 1'b0};
      end
      de  <= disp_on;
      pix <= disp_on ? cell_colour(px_bit, at_cur) : '0;
    end
  end

  assert_blank_is_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix == '0));
  assert_attr_after_bitmap_R5: assert property (@(posedge clk) disable iff (rst)
    cap_at |-> $past(cap_bm));
  assert_single_capture_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_bm, cap_at}));
endmodule

// File: rtl/attr_cell_fetch.sv
module attr_cell_fetch
  import acf_pkg::*;
#(
  parameter int H_TOTAL = 448,
  parameter int V_TOTAL = 312
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  rd_data,
  output logic        rd_en,
  output logic [12:0] rd_addr,
  output logic        cpu_ce,
  output logic        de,
  output logic [3:0]  pix
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hc, hc_nxt;
  logic [VW-1:0] vc, vc_nxt;
  logic          line_wrap, cap_bm, cap_at, load_cell, disp_on;

  assign disp_on = (hc < HW'(ACT_W)) && (vc < VW'(ACT_H));

  acf_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_raster (
    .clk(clk), .rst(rst), .hc(hc), .vc(vc),
    .hc_nxt(hc_nxt), .vc_nxt(vc_nxt), .line_wrap(line_wrap)
  );

  acf_fetch_seq #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_fetch (
    .clk(clk), .rst(rst), .hc(hc), .vc(vc), .hc_nxt(hc_nxt), .vc_nxt(vc_nxt),
    .rd_en(rd_en), .rd_addr(rd_addr), .cpu_ce(cpu_ce),
    .cap_bm(cap_bm), .cap_at(cap_at), .load_cell(load_cell)
  );

  acf_serializer u_ser (
    .clk(clk), .rst(rst), .rd_data(rd_data), .cap_bm(cap_bm), .cap_at(cap_at),
    .load_cell(load_cell), .disp_on(disp_on), .de(de), .pix(pix)
  );

  assert_load_on_cell_edge_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_on && hc[2:0] == 3'd0) |-> $past(load_cell));
  assert_wrap_is_slot_end_R2: assert property (@(posedge clk) disable iff (rst)
    line_wrap |-> load_cell);
endmodule

// File: tb/sim_attr_cell_fetch.sv
module sim_attr_cell_fetch;
  localparam int HT = 272;
  localparam int VT = 196;
  localparam int FRAME_PIX = 256 * 192;
  localparam int NPROBE = 8;
  // {x, y, bitmap address, attribute address}
  localparam int PROBE [NPROBE][4] = '{
    '{0, 0, 0, 6144}, '{31, 0, 31, 6175}, '{0, 1, 256, 6144}, '{0, 8, 32, 6176},
    '{5, 63, 2021, 6373}, '{0, 64, 2048, 6400}, '{17, 100, 3217, 6545}, '{31, 191, 6143, 6911}};

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic rd_en, cpu_ce, de;
  logic [12:0] rd_addr;
  logic [3:0] pix;

  int checks = 0, errors = 0, edges = 0, npix = 0, run = 0, lines = 0;
  int reads = 0, ce_low = 0, pat = 0, bit7_seen = 0;
  bit first_de_done = 0, finished = 0, mon_on = 0;

  always #2 clk = ~clk;

  attr_cell_fetch #(.H_TOTAL(HT), .V_TOTAL(VT)) u0 (
    .clk(clk), .rst(rst), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .cpu_ce(cpu_ce), .de(de), .pix(pix));

  function automatic logic [7:0] mem_byte(input int a, input int p);
    if (p == 0) return 8'((a * 173) + (a / 256) * 29 + 59);
    if (a < 6144) return 8'h0F ^ 8'(a);
    return 8'h80 | 8'((a * 7) % 128);
  endfunction

  function automatic int bm_ref(input int x, input int y);
    return (y / 64) * 2048 + (y % 8) * 256 + ((y / 8) % 8) * 32 + x;
  endfunction

  function automatic int at_ref(input int x, input int y);
    return 6144 + (y / 8) * 32 + x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst) edges++;
    if (rd_en) rd_data <= mem_byte(int'(rd_addr), pat);
  end

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      check(cpu_ce == !rd_en, "R8 ce", int'(cpu_ce), int'(!rd_en));
      if (!cpu_ce) ce_low++;
      if (rd_en) begin
        automatic int pair = (reads / 2) % 6144;
        automatic int cx = pair % 32;
        automatic int cy = pair / 32;
        if (reads % 2 == 0) check(int'(rd_addr) == bm_ref(cx, cy), "R3 bitmap addr", int'(rd_addr), bm_ref(cx, cy));
        else check(int'(rd_addr) == at_ref(cx, cy), "R4 attr addr", int'(rd_addr), at_ref(cx, cy));
        for (int i = 0; i < NPROBE; i++) begin
          if (PROBE[i][0] == cx && PROBE[i][1] == cy) begin
            if (reads % 2 == 0) check(int'(rd_addr) == PROBE[i][2], "R3 probe", int'(rd_addr), PROBE[i][2]);
            else check(int'(rd_addr) == PROBE[i][3], "R4 probe", int'(rd_addr), PROBE[i][3]);
          end
        end
        reads++;
      end
      if (!de) begin
        check(pix == 4'd0, "R9 blank pix", int'(pix), 0);
        if (run != 0) begin
          check(run == 256, "R2 run length", run, 256);
          lines++;
          run = 0;
        end
      end else begin
        automatic int p = npix % FRAME_PIX;
        automatic int f = npix / FRAME_PIX;
        automatic int x = p % 256;
        automatic int y = p / 256;
        automatic logic [7:0] bm = mem_byte(bm_ref(x / 8, y), f);
        automatic logic [7:0] at = mem_byte(at_ref(x / 8, y), f);
        automatic logic b = bm[7 - (x % 8)];
        automatic logic [3:0] exp = {at[6], (b ? at[2:0] : at[5:3])};
        if (!first_de_done) begin
          check(edges == HT + 1, "R2 first de", edges, HT + 1);
          first_de_done = 1;
        end
        if (at[7]) bit7_seen++;
        // R5: data taken one clock after the request; R6 ink/paper/bright; R7 in frame 2
        check(pix == exp, (f == 0) ? "R6 R5 pixel" : "R7 pixel", int'(pix), int'(exp));
        run++;
        npix++;
        if (npix == FRAME_PIX) pat = 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", npix, 2 * FRAME_PIX);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(de == 1'b0, "R1 de", int'(de), 0);
    check(pix == 4'd0, "R1 pix", int'(pix), 0);
    check(rd_en == 1'b0, "R1 rd_en", int'(rd_en), 0);
    check(cpu_ce == 1'b1, "R1 cpu_ce", int'(cpu_ce), 1);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    check(de == 1'b0, "R2 no early de", int'(de), 0);
    while (npix < 2 * FRAME_PIX) @(negedge clk);
    repeat (50) @(negedge clk);
    check(lines == 2 * 192, "R2 lines", lines, 2 * 192);
    check(ce_low == 2 * 2 * 32 * 192, "R8 ce low count", ce_low, 2 * 2 * 32 * 192);
    check(reads == 2 * 2 * 32 * 192, "R10 read count", reads, 2 * 2 * 32 * 192);
    check(bit7_seen > 0, "R7 bit7 exercised", bit7_seen, 1);
    mon_on = 0;
    rst = 1'b1;
    @(negedge clk);
    check(de == 1'b0, "R1 de again", int'(de), 0);
    check(pix == 4'd0, "R1 pix again", int'(pix), 0);
    check(rd_en == 1'b0, "R1 rd_en again", int'(rd_en), 0);
    check(cpu_ce == 1'b1, "R1 cpu_ce again", int'(cpu_ce), 1);
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule